// File: doc/BRIEF.md
# Duplicated Rate Decision Checker

This block watches a justification-rate comparator that is built twice. Each copy of the decision logic reports three flags: out of tolerance, positive stuff and negative stuff. The checker compares the two sets of flags every clock and raises an active-low error while they differ. It also compares two copies of a timing signal, and a mismatch there is held until software-independent hardware clears it with an error-clear input. A watchdog flags loss of input activity. At high data rates a count-512 tick from the word counter restarts the watchdog. At low rates the end-of-frame strobe restarts it.

An out-of-tolerance command from the first copy also drives a long active-low alarm. The alarm lasts a parameterised number of clock cycles, about 31 seconds in the field, and a new command restarts it. All outputs are registered. The block has no software access. Its errors go to an output selector that lies outside this block.

Top module: `rate_pair_monitor`

## Requirements
- R1: When any of the three decision flags of copy A differs from the same flag of copy B at a clock edge, `cmp_err_n` is 0 after that edge.
- R2: When all three flag pairs agree at a clock edge, `cmp_err_n` is 1 after that edge. The error therefore tracks disagreement and is not sticky.
- R3: If `a_oot` is 1 at a clock edge, `oot_alarm_n` is 0 after that edge.
- R4: `oot_alarm_n` returns to 1 exactly STRETCH_CYC edges after the last edge at which `a_oot` was 1. A new command during the alarm restarts this count. `b_oot` never starts the alarm.
- R5: If `tim_a` differs from `tim_b` at a clock edge, `tim_err_n` is 0 after that edge.
- R6: Once `tim_err_n` is 0 it stays 0 until `err_clr` is 1 at an edge with no timing mismatch. After that edge it is 1. If a mismatch and `err_clr` occur at the same edge, the error stays set.
- R7: `err_clr` has no effect on `cmp_err_n`, `oot_alarm_n` or `act_err_n`.
- R8: The watchdog restart source is `tick512` when `rate_hi` is 1 and `frame_end` when `rate_hi` is 0. The source that is not selected is ignored. After an edge with the selected source at 1, `act_err_n` is 1.
- R9: `act_err_n` becomes 0 after WDOG_CYC consecutive edges with no selected restart. It stays 0 until the next restart.
- R10: While reset is applied, and in the first cycle after the internal reset releases, all four outputs are 1. `rst_n` acts asynchronously and is released through a two-stage synchroniser, so internal state runs from the third rising edge after `rst_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| a_oot | input | 1 | Copy A out-of-tolerance flag |
| a_pos | input | 1 | Copy A positive-stuff flag |
| a_neg | input | 1 | Copy A negative-stuff flag |
| b_oot | input | 1 | Copy B out-of-tolerance flag |
| b_pos | input | 1 | Copy B positive-stuff flag |
| b_neg | input | 1 | Copy B negative-stuff flag |
| tim_a | input | 1 | Timing signal, first copy |
| tim_b | input | 1 | Timing signal, second copy |
| tick512 | input | 1 | Word-count-512 pulse (restart at high rate) |
| frame_end | input | 1 | End-of-frame strobe (restart at low rate) |
| rate_hi | input | 1 | 1 when the data rate is above 2 kbps |
| err_clr | input | 1 | Clears the sticky timing-mismatch error |
| cmp_err_n | output | 1 | Active-low decision-copy mismatch error |
| tim_err_n | output | 1 | Active-low sticky timing mismatch error |
| act_err_n | output | 1 | Active-low loss-of-activity error |
| oot_alarm_n | output | 1 | Active-low stretched out-of-tolerance alarm |

## Verification
The assertions treat every input as a synchronous level that is sampled once per rising edge. They make no assumption about pulse widths: a restart or command may be held for many cycles or may last one. Their checks start only one cycle after the internal synchronised reset releases. The stimulus changes every input on the falling edge. It draws decision flags that agree most of the time, so that both sides of R1 and R2 occur. It uses restart rates that both let the watchdog expire and hold it off. Out-of-tolerance commands are sparse, so that alarms both time out and restart.

// File: rtl/rpm_pkg.sv
package rpm_pkg;
  localparam int unsigned NFLAG = 3;
  // Bit order of a decision word: [2] out-of-tolerance, [1] positive, [0] negative
  typedef logic [NFLAG-1:0] decision_t;
  localparam int unsigned OOT_BIT = 2;
endpackage

// File: rtl/rpm_decision_cmp.sv
module rpm_decision_cmp
  import rpm_pkg::*;
(
  input  logic      clk,
  input  logic      rst_s,
  input  decision_t dec_a,
  input  decision_t dec_b,
  output logic      cmp_err_n
);
  logic [NFLAG-1:0] diff;
  logic             err_n_d;
  logic             err_n_q;

  // one XOR per flag pair
  for (genvar i = 0; i < NFLAG; i++) begin : g_pair
    assign diff[i] = dec_a[i] ^ dec_b[i];
  end

  always_comb begin
    err_n_d = ~(|diff);
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) err_n_q <= 1'b1;
    else        err_n_q <= err_n_d;
  end

  assign cmp_err_n = err_n_q;
endmodule

// File: rtl/rpm_oot_stretch.sv
module rpm_oot_stretch #(
  parameter int unsigned STRETCH_CYC = 1000
) (
  input  logic clk,
  input  logic rst_s,
  input  logic cmd,
  output logic alarm_n
);
  localparam int unsigned SW = $clog2(STRETCH_CYC + 1);
  localparam logic [SW-1:0] LOAD = SW'(STRETCH_CYC);

  logic [SW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          alarm_n_q, alarm_n_d;

  always_comb begin
    cnt_en    = cmd || (cnt_q != '0);
    cnt_d     = cmd ? LOAD : cnt_q - 1'b1;
    alarm_n_d = (cnt_d == '0);
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      cnt_q     <= '0;
      alarm_n_q <= 1'b1;
    end else if (cnt_en) begin
      cnt_q     <= cnt_d;
      alarm_n_q <= alarm_n_d;
    end
  end

  assign alarm_n = alarm_n_q;
endmodule

// File: rtl/rpm_timing_latch.sv
module rpm_timing_latch (
  input  logic clk,
  input  logic rst_s,
  input  logic tim_a,
  input  logic tim_b,
  input  logic clr,
  output logic err_n
);
  logic mis;
  logic held_q, held_d;

  always_comb begin
    mis = tim_a ^ tim_b;
    if (mis)      held_d = 1'b1;
    else if (clr) held_d = 1'b0;
    else          held_d = held_q;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) held_q <= 1'b0;
    else        held_q <= held_d;
  end

  assign err_n = ~held_q;
endmodule

// File: rtl/rpm_activity_dog.sv
module rpm_activity_dog #(
  parameter int unsigned WDOG_CYC = 500
) (
  input  logic clk,
  input  logic rst_s,
  input  logic rate_hi,
  input  logic tick512,
  input  logic frame_end,
  output logic act_err_n
);
  localparam int unsigned WW = $clog2(WDOG_CYC + 1);
  localparam logic [WW-1:0] LIMIT = WW'(WDOG_CYC);

  logic          kick;
  logic [WW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          err_n_q, err_n_d;

  always_comb begin
    kick    = rate_hi ? tick512 : frame_end;
    cnt_en  = kick || (cnt_q != LIMIT);
    cnt_d   = kick ? '0 : cnt_q + 1'b1;
    err_n_d = (cnt_d != LIMIT);
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      cnt_q   <= '0;
      err_n_q <= 1'b1;
    end else if (cnt_en) begin
      cnt_q   <= cnt_d;
      err_n_q <= err_n_d;
    end
  end

  assign act_err_n = err_n_q;
endmodule

// File: rtl/rate_pair_monitor.sv
module rate_pair_monitor
  import rpm_pkg::*;
#(
  parameter int unsigned STRETCH_CYC = 1000,
  parameter int unsigned WDOG_CYC    = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic a_oot,
  input  logic a_pos,
  input  logic a_neg,
  input  logic b_oot,
  input  logic b_pos,
  input  logic b_neg,
  input  logic tim_a,
  input  logic tim_b,
  input  logic tick512,
  input  logic frame_end,
  input  logic rate_hi,
  input  logic err_clr,
  output logic cmp_err_n,
  output logic tim_err_n,
  output logic act_err_n,
  output logic oot_alarm_n
);
  logic [1:0] rsync_q;
  logic       rst_s;
  decision_t  dec_a, dec_b;

  // assert asynchronously, release on the second edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_s = rsync_q[1];

  assign dec_a = {a_oot, a_pos, a_neg};
  assign dec_b = {b_oot, b_pos, b_neg};

  rpm_decision_cmp u_cmp (
    .clk(clk), .rst_s(rst_s), .dec_a(dec_a), .dec_b(dec_b), .cmp_err_n(cmp_err_n)
  );

  rpm_oot_stretch #(.STRETCH_CYC(STRETCH_CYC)) u_oot (
    .clk(clk), .rst_s(rst_s), .cmd(dec_a[OOT_BIT]), .alarm_n(oot_alarm_n)
  );

  rpm_timing_latch u_tim (
    .clk(clk), .rst_s(rst_s), .tim_a(tim_a), .tim_b(tim_b), .clr(err_clr), .err_n(tim_err_n)
  );

  rpm_activity_dog #(.WDOG_CYC(WDOG_CYC)) u_dog (
    .clk(clk), .rst_s(rst_s), .rate_hi(rate_hi), .tick512(tick512),
    .frame_end(frame_end), .act_err_n(act_err_n)
  );
endmodule

// File: rtl/rpm_checker.sv
module rpm_checker #(
  parameter int unsigned STRETCH_CYC = 1000
) (
  input logic clk,
  input logic rst_s,
  input logic a_oot, a_pos, a_neg,
  input logic b_oot, b_pos, b_neg,
  input logic tim_a, tim_b,
  input logic tick512, frame_end, rate_hi, err_clr,
  input logic cmp_err_n, tim_err_n, act_err_n, oot_alarm_n
);
  logic        armed;
  logic [31:0] since_cmd;
  logic        mism, kick;

  assign mism = (a_oot ^ b_oot) | (a_pos ^ b_pos) | (a_neg ^ b_neg);
  assign kick = rate_hi ? tick512 : frame_end;

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  // edges since the last out-of-tolerance command, saturating past the stretch
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s)                          since_cmd <= STRETCH_CYC + 1;
    else if (a_oot)                      since_cmd <= 32'd1;
    else if (since_cmd <= STRETCH_CYC)   since_cmd <= since_cmd + 32'd1;
  end

  a_r1_mismatch_flags: assert property (@(posedge clk) disable iff (!rst_s)
    armed && mism |=> !cmp_err_n);
  a_r2_agree_clears: assert property (@(posedge clk) disable iff (!rst_s)
    armed && !mism |=> cmp_err_n);
  a_r3_cmd_alarms: assert property (@(posedge clk) disable iff (!rst_s)
    armed && a_oot |=> !oot_alarm_n);
  a_r4_stretch_len: assert property (@(posedge clk) disable iff (!rst_s)
    armed |-> (oot_alarm_n == (since_cmd > STRETCH_CYC)));
  a_r5_tim_sets: assert property (@(posedge clk) disable iff (!rst_s)
    armed && (tim_a ^ tim_b) |=> !tim_err_n);
  a_r6_tim_sticky: assert property (@(posedge clk) disable iff (!rst_s)
    armed && !tim_err_n && !err_clr |=> !tim_err_n);
  a_r6_tim_clear: assert property (@(posedge clk) disable iff (!rst_s)
    armed && err_clr && !(tim_a ^ tim_b) |=> tim_err_n);
  a_r8_kick_clears: assert property (@(posedge clk) disable iff (!rst_s)
    armed && kick |=> act_err_n);
  a_r9_err_holds: assert property (@(posedge clk) disable iff (!rst_s)
    armed && !act_err_n && !kick |=> !act_err_n);
endmodule

bind rate_pair_monitor rpm_checker #(.STRETCH_CYC(STRETCH_CYC)) u_chk (
  .clk(clk), .rst_s(rst_s),
  .a_oot(a_oot), .a_pos(a_pos), .a_neg(a_neg),
  .b_oot(b_oot), .b_pos(b_pos), .b_neg(b_neg),
  .tim_a(tim_a), .tim_b(tim_b),
  .tick512(tick512), .frame_end(frame_end), .rate_hi(rate_hi), .err_clr(err_clr),
  .cmp_err_n(cmp_err_n), .tim_err_n(tim_err_n), .act_err_n(act_err_n),
  .oot_alarm_n(oot_alarm_n)
);

// File: tb/sim_rate_pair_monitor.sv
`timescale 1ns/1ps
module sim_rate_pair_monitor;
  localparam int S = 20;
  localparam int W = 40;

  logic clk = 1'b0;
  logic rst_n;
  logic a_oot, a_pos, a_neg, b_oot, b_pos, b_neg;
  logic tim_a, tim_b, tick512, frame_end, rate_hi, err_clr;
  logic cmp_err_n, tim_err_n, act_err_n, oot_alarm_n;

  int n_chk = 0;
  int n_bad = 0;

  // bench model state
  int  m_oot;
  bit  m_tim;
  int  m_wd;
  bit  m_cmp_err;

  always #2.5 clk = ~clk;

  rate_pair_monitor #(.STRETCH_CYC(S), .WDOG_CYC(W)) u0 (
    .clk(clk), .rst_n(rst_n),
    .a_oot(a_oot), .a_pos(a_pos), .a_neg(a_neg),
    .b_oot(b_oot), .b_pos(b_pos), .b_neg(b_neg),
    .tim_a(tim_a), .tim_b(tim_b), .tick512(tick512), .frame_end(frame_end),
    .rate_hi(rate_hi), .err_clr(err_clr),
    .cmp_err_n(cmp_err_n), .tim_err_n(tim_err_n), .act_err_n(act_err_n),
    .oot_alarm_n(oot_alarm_n)
  );

  function automatic bit exp_kick();
    return rate_hi ? tick512 : frame_end;
  endfunction

  task automatic chk(string tag, logic got, logic exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s t=%0t got=%b exp=%b", tag, $time, got, exp);
    end
  endtask

  task automatic model_edge();
    m_cmp_err = (a_oot != b_oot) || (a_pos != b_pos) || (a_neg != b_neg);
    if (a_oot) m_oot = S; else if (m_oot > 0) m_oot--;
    if (tim_a != tim_b) m_tim = 1'b1; else if (err_clr) m_tim = 1'b0;
    if (exp_kick()) m_wd = 0; else if (m_wd < W) m_wd++;
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk("R1 cmp", cmp_err_n, !m_cmp_err);
    chk("R4 oot", oot_alarm_n, m_oot == 0);
    chk("R6 tim", tim_err_n, !m_tim);
    chk("R9 act", act_err_n, m_wd != W);
  endtask

  task automatic idle();
    {a_oot, a_pos, a_neg, b_oot, b_pos, b_neg} = '0;
    {tim_a, tim_b, tick512, frame_end, rate_hi, err_clr} = '0;
  endtask

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    idle();
    rst_n = 1'b0;
    m_oot = 0; m_tim = 0; m_wd = 0; m_cmp_err = 0;
    repeat (3) @(negedge clk);
    // R10: outputs idle during reset
    chk("R10 rst cmp", cmp_err_n, 1'b1);
    chk("R10 rst oot", oot_alarm_n, 1'b1);
    chk("R10 rst tim", tim_err_n, 1'b1);
    chk("R10 rst act", act_err_n, 1'b1);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R10 post cmp", cmp_err_n, 1'b1);
    chk("R10 post act", act_err_n, 1'b1);

    // R1 / R2: single-flag differences, then agreement
    a_pos = 1'b1; step(); chk("R1 pos", cmp_err_n, 1'b0);
    a_pos = 1'b0; b_neg = 1'b1; step(); chk("R1 neg", cmp_err_n, 1'b0);
    b_neg = 1'b0; b_oot = 1'b1; step(); chk("R1 oot", cmp_err_n, 1'b0);
    b_oot = 1'b0; step(); chk("R2 agree", cmp_err_n, 1'b1);
    chk("R4 b_oot no alarm", oot_alarm_n, 1'b1);

    // R8 / R9: low rate, frame_end restarts, tick512 ignored
    frame_end = 1'b1; step(); frame_end = 1'b0;
    for (int k = 0; k < W - 1; k++) begin
      tick512 = (k % 5 == 0);
      step();
    end
    tick512 = 1'b0;
    chk("R8 tick ignored", act_err_n, 1'b1);
    step(); chk("R9 timeout", act_err_n, 1'b0);
    rate_hi = 1'b1; frame_end = 1'b1; step(); chk("R8 frame ignored hi", act_err_n, 1'b0);
    frame_end = 1'b0; tick512 = 1'b1; step(); chk("R8 tick restarts", act_err_n, 1'b1);
    tick512 = 1'b0; rate_hi = 1'b0;

    // R3 / R4: stretch, restart, expiry; R7 err_clr has no effect
    a_oot = 1'b1; b_oot = 1'b1; step(); chk("R3 alarm", oot_alarm_n, 1'b0);
    a_oot = 1'b0; b_oot = 1'b0;
    for (int k = 0; k < S - 2; k++) step();
    a_oot = 1'b1; b_oot = 1'b1; step(); a_oot = 1'b0; b_oot = 1'b0;
    err_clr = 1'b1; step(); chk("R7 clr keeps alarm", oot_alarm_n, 1'b0);
    err_clr = 1'b0;
    for (int k = 0; k < S - 2; k++) step();
    chk("R4 still on", oot_alarm_n, 1'b0);
    step(); chk("R4 expired", oot_alarm_n, 1'b1);

    // R5 / R6: sticky, set wins over clear, clear
    frame_end = 1'b1;
    tim_a = 1'b1; step(); chk("R5 set", tim_err_n, 1'b0);
    tim_a = 1'b0; repeat (3) step(); chk("R6 held", tim_err_n, 1'b0);
    tim_b = 1'b1; err_clr = 1'b1; step(); chk("R6 set wins", tim_err_n, 1'b0);
    tim_b = 1'b0; step(); chk("R6 cleared", tim_err_n, 1'b1);
    err_clr = 1'b0; frame_end = 1'b0;

    // constrained random mix
    for (int k = 0; k < 4000; k++) begin
      logic [2:0] av;
      av = 3'($urandom);
      {a_oot, a_pos, a_neg} = av;
      if (($urandom % 8) == 0) av = av ^ (3'b1 << ($urandom % 3));
      {b_oot, b_pos, b_neg} = av;
      if (($urandom % 16) != 0) a_oot = 1'b0;
      if (a_oot == 1'b0 && ($urandom % 8) != 0) b_oot = a_oot;
      tim_a = 1'($urandom);
      tim_b = (($urandom % 20) == 0) ? ~tim_a : tim_a;
      err_clr = (($urandom % 10) == 0);
      if (($urandom % 200) == 0) rate_hi = ~rate_hi;
      tick512 = (($urandom % (W / 2 + (k % 3) * W / 2)) == 0);
      frame_end = (($urandom % (W / 2 + (k % 3) * W / 2)) == 0);
      step();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule